// File: doc/BRIEF.md
# Nested Two-Stage Address Translation Walker

This block turns a guest virtual address into a host physical address when a guest runs under a hypervisor. It walks the guest's own multi-level page tables to reach a guest physical address. The guest table root and every pointer found in a guest entry are guest physical addresses, not host ones. So before each guest table read the walker runs a complete walk of the hypervisor's nested tables to find where that entry sits in host memory. When the guest walk is finished, one more nested walk maps the final guest physical address to the host physical result.

A requester presents an address with a valid/ready handshake. The walker samples the guest root and the nested root at that moment and issues every table read through one memory port. The reads go out strictly one after another, because each table address depends on the entry read just before it. When it is done, it pulses a response that carries the host address or a fault report, together with the number of nested-table reads and guest-table reads it made. There is no translation caching and there are no large pages, so each translation pays the full two-dimensional cost.

Top module: `nested_xlate_walker`

## Requirements
- R1: After reset, reqReady is 1 and memReq and rspValid are 0.
- R2: A request is accepted in a cycle where reqValid and reqReady are both 1. From the next cycle until the response, reqReady is 0 and reqValid is ignored. guestRoot and nestRoot are sampled at acceptance, and later changes to them do not affect that translation.
- R3: A table entry is 64 bits. Bit 0 is the valid flag and bits [47:12] give the next table or frame address. All other bits are ignored. An entry address is the page-aligned table base plus 8 times a 9-bit index, so memAddr bits [2:0] are always 0. At level k of a depth-D walk (level 0 is the root), the index is taken from bits [12+9*(D-1-k) +: 9] of the address being translated: the virtual address for guest levels, the guest physical address for nested levels.
- R4: Each guest level makes Ln nested reads, then one guest read. The nested reads translate the guest entry address, and the guest read uses host address = nested leaf frame OR low 12 bits of that guest entry address. After the last guest level, Ln more nested reads translate the final guest physical address, which is the guest leaf frame OR reqVa[11:0].
- R5: On success, rspHpa is the final nested leaf frame OR reqVa[11:0], and rspFault is 0.
- R6: A successful translation reports exactly Lg*Ln+Ln nested reads and Lg guest reads (20 and 4 at default depths).
- R7: A nested read whose entry has bit 0 clear ends the walk at once. The response then has rspFault = 1, rspGuestLvl set to the guest level being served (Lg for the final walk), rspNestLvl set to the nested level, rspHpa = 0, and read counts that include the faulting read.
- R8: A guest read whose entry has bit 0 clear ends the walk with rspFault = 2, rspGuestLvl set to that guest level, rspNestLvl = 0, rspHpa = 0, and read counts that include the faulting read.
- R9: memReq stays high with memAddr unchanged until memAck arrives. Only one read is outstanding at a time, and memData is taken in the cycle memAck is high.
- R10: rspValid is high for exactly one cycle for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and able to accept |
| reqVa | input | 48 | Guest virtual address to translate |
| guestRoot | input | 48 | Guest top-level table base (guest physical) |
| nestRoot | input | 48 | Nested top-level table base (host physical) |
| rspValid | output | 1 | One-cycle response strobe |
| rspHpa | output | 48 | Resulting host physical address, 0 on fault |
| rspFault | output | 2 | 0 none, 1 nested fault, 2 guest fault |
| rspGuestLvl | output | 3 | Guest level of the fault (Lg = final walk) |
| rspNestLvl | output | 2 | Nested level of a nested fault |
| rspNestReads | output | 5 | Nested-table reads issued |
| rspGuestReads | output | 5 | Guest-table reads issued |
| memReq | output | 1 | Table read request |
| memAddr | output | 48 | Host address of the table entry |
| memAck | input | 1 | Read completion, data valid |
| memData | input | 64 | Entry read from memory |

## Verification
The hardest cases to reach are faults deep inside the interleaving. Examples are an invalid entry at a middle nested level while a middle guest level is being served, and an invalid entry in the last nested walk after all guest reads have finished. The bench memory model builds tables whose contents follow from their own addresses, so any walk path is valid. It then computes the exact host address of the Nth read and clears the valid bit of only that one entry. Every read address the walker issues is compared in order with an independently computed list. This exposes any mistake in interleaving or indexing, even when the final address happens to come out correct.

// File: rtl/nxw_pkg.sv
package nxw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_NEST  = 2'd1,
    FLT_GUEST = 2'd2
  } fltKind_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadReq;     // capture request and roots, set up first entry address
    logic readGuest;   // memory port addresses the guest entry
    logic nestStep;    // descend one nested level
    logic latchHost;   // nested leaf reached for a guest entry address
    logic finishOk;    // nested leaf reached for the final guest physical address
    logic guestStep;   // descend one guest level
    logic enterFinal;  // guest leaf reached, start the final nested walk
    logic countNest;   // a nested read completed
    logic countGuest;  // a guest read completed
    logic nestFault;   // invalid nested entry
    logic guestFault;  // invalid guest entry
  } walkCmd_t;

endpackage

// File: rtl/nxw_ctrl.sv
module nxw_ctrl
  import nxw_pkg::*;
#(
  parameter int GUEST_LVLS = 4,
  parameter int NEST_LVLS  = 4,
  parameter int GL_W       = 3,
  parameter int NL_W       = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic            memAck,
  input  logic            entryValid,
  output logic            memReq,
  output logic            rspValid,
  output logic [GL_W-1:0] gLvl,
  output logic [NL_W-1:0] nLvl,
  output walkCmd_t        cmd
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_NWALK = 2'd1,
    ST_GREAD = 2'd2,
    ST_RESP  = 2'd3
  } walkState_t;

  localparam logic [NL_W-1:0] N_LAST  = NL_W'(NEST_LVLS - 1);
  localparam logic [GL_W-1:0] G_LAST  = GL_W'(GUEST_LVLS - 1);
  localparam logic [GL_W-1:0] G_FINAL = GL_W'(GUEST_LVLS);

  walkState_t stateQ, stateD;
  logic [GL_W-1:0] gLvlQ, gLvlD;
  logic [NL_W-1:0] nLvlQ, nLvlD;

  always_comb begin
    stateD = stateQ;
    gLvlD  = gLvlQ;
    nLvlD  = nLvlQ;
    cmd    = '0;
    cmd.readGuest = (stateQ == ST_GREAD);
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          cmd.loadReq = 1'b1;
          gLvlD  = '0;
          nLvlD  = '0;
          stateD = ST_NWALK;
        end
      end
      ST_NWALK: begin
        if (memAck) begin
          cmd.countNest = 1'b1;
          if (!entryValid) begin
            cmd.nestFault = 1'b1;
            stateD = ST_RESP;
          end else if (nLvlQ == N_LAST) begin
            nLvlD = '0;
            if (gLvlQ == G_FINAL) begin
              cmd.finishOk = 1'b1;
              stateD = ST_RESP;
            end else begin
              cmd.latchHost = 1'b1;
              stateD = ST_GREAD;
            end
          end else begin
            cmd.nestStep = 1'b1;
            nLvlD = nLvlQ + NL_W'(1);
          end
        end
      end
      ST_GREAD: begin
        if (memAck) begin
          cmd.countGuest = 1'b1;
          if (!entryValid) begin
            cmd.guestFault = 1'b1;
            stateD = ST_RESP;
          end else if (gLvlQ == G_LAST) begin
            cmd.enterFinal = 1'b1;
            gLvlD  = G_FINAL;
            stateD = ST_NWALK;
          end else begin
            cmd.guestStep = 1'b1;
            gLvlD  = gLvlQ + GL_W'(1);
            stateD = ST_NWALK;
          end
        end
      end
      ST_RESP: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      gLvlQ  <= '0;
      nLvlQ  <= '0;
    end else begin
      stateQ <= stateD;
      gLvlQ  <= gLvlD;
      nLvlQ  <= nLvlD;
    end
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign memReq   = (stateQ == ST_NWALK) || (stateQ == ST_GREAD);
  assign rspValid = (stateQ == ST_RESP);
  assign gLvl     = gLvlQ;
  assign nLvl     = nLvlQ;

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN) memReq |-> !reqReady); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN) (memReq && !memAck) |=> memReq); // R9
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rstN) rspValid |=> !rspValid); // R10
  AST_NLVL_RANGE: assert property (@(posedge clk) disable iff (!rstN) memReq |-> (int'(nLvl) < NEST_LVLS)); // R4
  AST_GLVL_RANGE: assert property (@(posedge clk) disable iff (!rstN) memReq |-> (int'(gLvl) <= GUEST_LVLS)); // R4

endmodule

// File: rtl/nxw_path.sv
module nxw_path
  import nxw_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int DATA_W     = 64,
  parameter int PAGE_BITS  = 12,
  parameter int IDX_BITS   = 9,
  parameter int GUEST_LVLS = 4,
  parameter int NEST_LVLS  = 4,
  parameter int GL_W       = 3,
  parameter int NL_W       = 2,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCmd_t          cmd,
  input  logic [GL_W-1:0]   gLvl,
  input  logic [NL_W-1:0]   nLvl,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic [ADDR_W-1:0] guestRoot,
  input  logic [ADDR_W-1:0] nestRoot,
  input  logic [DATA_W-1:0] memData,
  output logic              entryValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] rspHpa,
  output fltKind_t          rspFault,
  output logic [GL_W-1:0]   rspGuestLvl,
  output logic [NL_W-1:0]   rspNestLvl,
  output logic [CNT_W-1:0]  rspNestReads,
  output logic [CNT_W-1:0]  rspGuestReads
);

  localparam int OFS_W      = $clog2(DATA_W / 8);
  localparam int NEST_TOTAL = GUEST_LVLS * NEST_LVLS + NEST_LVLS;

  function automatic logic [IDX_BITS-1:0] pickIdx(input logic [ADDR_W-1:0] a,
                                                  input int lvl, input int depth);
    int sh;
    sh = PAGE_BITS + IDX_BITS * (depth - 1 - lvl);
    if (sh < PAGE_BITS) sh = PAGE_BITS;
    return IDX_BITS'(a >> sh);
  endfunction

  function automatic logic [ADDR_W-1:0] entryOfs(input logic [IDX_BITS-1:0] idx);
    return {{(ADDR_W - IDX_BITS - OFS_W){1'b0}}, idx, {OFS_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] pageOf(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  endfunction

  logic [ADDR_W-1:0] vaQ;         // request address
  logic [ADDR_W-1:0] targetQ;     // guest physical address under nested translation
  logic [ADDR_W-1:0] nTableQ;     // current nested table base (host)
  logic [ADDR_W-1:0] nRootQ;      // nested root sampled at acceptance
  logic [ADDR_W-1:0] hostAddrQ;   // host address of the pending guest entry
  logic [ADDR_W-1:0] hpaQ;
  fltKind_t          faultQ;
  logic [GL_W-1:0]   fltGQ;
  logic [NL_W-1:0]   fltNQ;
  logic [CNT_W-1:0]  nestCntQ;
  logic [CNT_W-1:0]  guestCntQ;

  logic [ADDR_W-1:0] entryFrame;
  logic [ADDR_W-1:0] nestEntryAddr;
  logic [ADDR_W-1:0] leafAddr;
  logic              unusedEntryBits;

  assign entryValid      = memData[0];
  assign entryFrame      = {memData[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  assign unusedEntryBits = ^{memData[DATA_W-1:ADDR_W], memData[PAGE_BITS-1:1]};
  assign nestEntryAddr   = nTableQ + entryOfs(pickIdx(targetQ, int'(nLvl), NEST_LVLS));
  assign leafAddr        = {entryFrame[ADDR_W-1:PAGE_BITS], targetQ[PAGE_BITS-1:0]};
  assign memAddr         = cmd.readGuest ? hostAddrQ : nestEntryAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ       <= '0;
      targetQ   <= '0;
      nTableQ   <= '0;
      nRootQ    <= '0;
      hostAddrQ <= '0;
      hpaQ      <= '0;
      faultQ    <= FLT_NONE;
      fltGQ     <= '0;
      fltNQ     <= '0;
      nestCntQ  <= '0;
      guestCntQ <= '0;
    end else begin
      if (cmd.loadReq) begin
        vaQ       <= reqVa;
        nRootQ    <= pageOf(nestRoot);
        nTableQ   <= pageOf(nestRoot);
        targetQ   <= pageOf(guestRoot) + entryOfs(pickIdx(reqVa, 0, GUEST_LVLS));
        nestCntQ  <= '0;
        guestCntQ <= '0;
      end
      if (cmd.countNest)  nestCntQ  <= nestCntQ + CNT_W'(1);
      if (cmd.countGuest) guestCntQ <= guestCntQ + CNT_W'(1);
      if (cmd.nestStep)   nTableQ   <= entryFrame;
      if (cmd.latchHost)  hostAddrQ <= leafAddr;
      if (cmd.guestStep) begin
        targetQ <= entryFrame + entryOfs(pickIdx(vaQ, int'(gLvl) + 1, GUEST_LVLS));
        nTableQ <= nRootQ;
      end
      if (cmd.enterFinal) begin
        targetQ <= {entryFrame[ADDR_W-1:PAGE_BITS], vaQ[PAGE_BITS-1:0]};
        nTableQ <= nRootQ;
      end
      if (cmd.finishOk) begin
        hpaQ   <= leafAddr;
        faultQ <= FLT_NONE;
        fltGQ  <= '0;
        fltNQ  <= '0;
      end
      if (cmd.nestFault) begin
        hpaQ   <= '0;
        faultQ <= FLT_NEST;
        fltGQ  <= gLvl;
        fltNQ  <= nLvl;
      end
      if (cmd.guestFault) begin
        hpaQ   <= '0;
        faultQ <= FLT_GUEST;
        fltGQ  <= gLvl;
        fltNQ  <= '0;
      end
    end
  end

  assign rspHpa        = hpaQ;
  assign rspFault      = faultQ;
  assign rspGuestLvl   = fltGQ;
  assign rspNestLvl    = fltNQ;
  assign rspNestReads  = nestCntQ;
  assign rspGuestReads = guestCntQ;

  AST_OK_COUNTS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.finishOk |=> (int'(nestCntQ) == NEST_TOTAL) && (int'(guestCntQ) == GUEST_LVLS)); // R6
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadReq |=> (nestCntQ == '0) && (guestCntQ == '0)); // R6
  AST_HOST_PAGE_OFS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.readGuest |-> (hostAddrQ[PAGE_BITS-1:0] == targetQ[PAGE_BITS-1:0])); // R4
  AST_FAULT_ZERO_HPA: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.nestFault || cmd.guestFault) |=> (rspHpa == '0) && (rspFault != FLT_NONE)); // R7

endmodule

// File: rtl/nested_xlate_walker.sv
module nested_xlate_walker
  import nxw_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int DATA_W     = 64,
  parameter int PAGE_BITS  = 12,
  parameter int IDX_BITS   = 9,
  parameter int GUEST_LVLS = 4,
  parameter int NEST_LVLS  = 4,
  localparam int GL_W      = $clog2(GUEST_LVLS + 1),
  localparam int NL_W      = (NEST_LVLS > 1) ? $clog2(NEST_LVLS) : 1,
  localparam int CNT_W     = $clog2(GUEST_LVLS * NEST_LVLS + NEST_LVLS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic [ADDR_W-1:0] guestRoot,
  input  logic [ADDR_W-1:0] nestRoot,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspHpa,
  output logic [1:0]        rspFault,
  output logic [GL_W-1:0]   rspGuestLvl,
  output logic [NL_W-1:0]   rspNestLvl,
  output logic [CNT_W-1:0]  rspNestReads,
  output logic [CNT_W-1:0]  rspGuestReads,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData
);

  localparam int OFS_W = $clog2(DATA_W / 8);

  walkCmd_t        cmd;
  logic [GL_W-1:0] gLvl;
  logic [NL_W-1:0] nLvl;
  logic            entryValid;
  fltKind_t        fault;

  nxw_ctrl #(
    .GUEST_LVLS(GUEST_LVLS), .NEST_LVLS(NEST_LVLS), .GL_W(GL_W), .NL_W(NL_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .memAck(memAck), .entryValid(entryValid), .memReq(memReq),
    .rspValid(rspValid), .gLvl(gLvl), .nLvl(nLvl), .cmd(cmd)
  );

  nxw_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS),
    .GUEST_LVLS(GUEST_LVLS), .NEST_LVLS(NEST_LVLS), .GL_W(GL_W), .NL_W(NL_W), .CNT_W(CNT_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .gLvl(gLvl), .nLvl(nLvl),
    .reqVa(reqVa), .guestRoot(guestRoot), .nestRoot(nestRoot), .memData(memData),
    .entryValid(entryValid), .memAddr(memAddr), .rspHpa(rspHpa), .rspFault(fault),
    .rspGuestLvl(rspGuestLvl), .rspNestLvl(rspNestLvl),
    .rspNestReads(rspNestReads), .rspGuestReads(rspGuestReads)
  );

  assign rspFault = fault;

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[OFS_W-1:0] == '0)); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr)); // R9
  AST_IDLE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady); // R10

endmodule

// File: tb/tb_nested_xlate_walker.sv
`timescale 1ns/1ps
module tb_nested_xlate_walker;

  localparam int LG = 4;
  localparam int LN = 4;
  localparam int SEQ_MAX = LG * (LN + 1) + LN;
  localparam logic [63:0] HOFF  = 64'h0000_8000_0000_0000;
  localparam logic [63:0] ONE40 = 64'h0000_0100_0000_0000;
  localparam logic [63:0] DATAB = 64'h0000_0500_0000_0000;

  // vector table: va, fault kind (0 none,1 nested,2 guest), guest level, nested level
  localparam int NV = 8;
  localparam logic [63:0] VEC_VA [NV] = '{
    64'h0000_0012_3456_7ABC, 64'h0000_0000_0000_0000, 64'h0000_00FF_FFFF_FFF8,
    64'h0000_0080_0000_1000, 64'h0000_0001_2345_6000, 64'h0000_0033_3333_3333,
    64'h0000_0044_0000_0FFF, 64'h0000_0055_5555_5000 };
  localparam int VEC_KIND [NV] = '{0, 0, 0, 1, 1, 2, 1, 2};
  localparam int VEC_G    [NV] = '{0, 0, 0, 0, 2, 1, 4, 3};
  localparam int VEC_N    [NV] = '{0, 0, 0, 0, 1, 0, 3, 0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqVa = '0;
  logic [47:0] guestRoot = ONE40[47:0];
  logic [47:0] nestRoot = ONE40[47:0];
  logic        rspValid;
  logic [47:0] rspHpa;
  logic [1:0]  rspFault;
  logic [2:0]  rspGuestLvl;
  logic [1:0]  rspNestLvl;
  logic [4:0]  rspNestReads;
  logic [4:0]  rspGuestReads;
  logic        memReq;
  logic [47:0] memAddr;
  logic        memAck = 1'b0;
  logic [63:0] memData = '0;

  int checks = 0;
  int errors = 0;
  int rdCnt = 0;
  int seqErr = 0;
  logic [63:0] badAddr = '1;
  logic [63:0] expSeq [SEQ_MAX];

  always #2 clk = ~clk;

  nested_xlate_walker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa),
    .guestRoot(guestRoot), .nestRoot(nestRoot), .rspValid(rspValid), .rspHpa(rspHpa),
    .rspFault(rspFault), .rspGuestLvl(rspGuestLvl), .rspNestLvl(rspNestLvl),
    .rspNestReads(rspNestReads), .rspGuestReads(rspGuestReads),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData)
  );

  function automatic logic [63:0] tblBase(input logic [63:0] a, input int lvl, input int depth);
    if (lvl == 0) return ONE40;
    return 64'(lvl + 1) * ONE40 + ((a >> (12 + 9 * (depth - lvl))) << 12);
  endfunction

  function automatic logic [63:0] idxOfs(input logic [63:0] a, input int lvl, input int depth);
    return ((a >> (12 + 9 * (depth - 1 - lvl))) & 64'h1FF) << 3;
  endfunction

  // tables whose contents follow from their own location; garbage in ignored bits
  function automatic logic [63:0] memModel(input logic [63:0] addr);
    logic [63:0] base, prefix, nxt, sub;
    int lvl;
    sub = addr[47] ? (addr & ~HOFF) : addr;
    lvl = int'(sub[47:40]) - 1;
    base = 64'(lvl + 1) * ONE40;
    prefix = (sub - base) >> 12;
    prefix = (prefix << 9) | ((sub >> 3) & 64'h1FF);
    if (addr[47]) nxt = (lvl < LG - 1) ? 64'(lvl + 2) * ONE40 + (prefix << 12) : DATAB + (prefix << 12);
    else          nxt = (lvl < LN - 1) ? 64'(lvl + 2) * ONE40 + (prefix << 12) : (prefix << 12) + HOFF;
    nxt = 64'hABCD_0000_0000_0006 | nxt | 64'h1;
    if (addr == badAddr) nxt = nxt & ~64'h1;
    return nxt;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
    end else begin
      if (memReq && memAck) begin
        if (rdCnt < SEQ_MAX) begin
          if ({16'h0, memAddr} != expSeq[rdCnt]) seqErr = seqErr + 1;
        end else seqErr = seqErr + 1;
        rdCnt = rdCnt + 1;
      end
      memAck  <= memReq && !memAck;
      memData <= memModel({16'h0, memAddr});
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic buildSeq(input logic [63:0] va);
    logic [63:0] tgt;
    for (int g = 0; g < LG; g++) begin
      tgt = tblBase(va, g, LG) + idxOfs(va, g, LG);
      for (int n = 0; n < LN; n++)
        expSeq[g * (LN + 1) + n] = tblBase(tgt, n, LN) + idxOfs(tgt, n, LN);
      expSeq[g * (LN + 1) + LN] = tgt + HOFF;
    end
    tgt = DATAB + va;
    for (int n = 0; n < LN; n++)
      expSeq[LG * (LN + 1) + n] = tblBase(tgt, n, LN) + idxOfs(tgt, n, LN);
  endtask

  task automatic runOne(input logic [63:0] va, input int kind, input int fg, input int fn,
                        input bit scramble);
    int expReads, expGuest, expNest, waitCyc;
    logic [63:0] expHpa;
    bit got;
    buildSeq(va);
    if (kind == 1) begin
      expReads = fg * (LN + 1) + fn + 1; badAddr = expSeq[expReads - 1]; expGuest = fg;
    end else if (kind == 2) begin
      expReads = fg * (LN + 1) + LN + 1; badAddr = expSeq[expReads - 1]; expGuest = fg + 1;
    end else begin
      expReads = SEQ_MAX; badAddr = '1; expGuest = LG;
    end
    expNest = expReads - expGuest;
    expHpa = (kind == 0) ? (HOFF + DATAB + va) : 64'h0;
    @(negedge clk);
    rdCnt = 0; seqErr = 0;
    reqVa = va[47:0]; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R2 busy after accept", 64'(reqReady), 64'h0);
    if (scramble) begin
      guestRoot = 48'hDEAD_BEEF_F000; nestRoot = 48'h0BAD_0BAD_0000;
      reqVa = 48'h0000_1111_2000; reqValid = 1'b1;
      repeat (6) @(negedge clk);
      reqValid = 1'b0;
    end
    got = 1'b0; waitCyc = 0;
    while (!got && waitCyc < 2000) begin
      if (rspValid) got = 1'b1;
      else begin @(negedge clk); waitCyc++; end
    end
    if (!got) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=0 expected=1");
      finishRun();
    end
    check(64'(rspHpa) == expHpa, "R5/R7 hpa", 64'(rspHpa), expHpa);
    check(int'(rspFault) == kind, "R7/R8 fault code", 64'(rspFault), 64'(kind));
    check(int'(rspNestReads) == expNest, "R6 nested read count", 64'(rspNestReads), 64'(expNest));
    check(int'(rspGuestReads) == expGuest, "R6 guest read count", 64'(rspGuestReads), 64'(expGuest));
    check(seqErr == 0 && rdCnt == expReads, "R4/R3 read sequence", 64'(rdCnt), 64'(expReads));
    if (kind != 0) begin
      check(int'(rspGuestLvl) == fg, "R7/R8 guest level", 64'(rspGuestLvl), 64'(fg));
      check(int'(rspNestLvl) == ((kind == 1) ? fn : 0), "R7/R8 nested level", 64'(rspNestLvl),
            64'((kind == 1) ? fn : 0));
    end
    @(negedge clk);
    check(rspValid == 1'b0, "R10 single pulse", 64'(rspValid), 64'h0);
    check(reqReady == 1'b1, "R2 ready after response", 64'(reqReady), 64'h1);
    guestRoot = ONE40[47:0]; nestRoot = ONE40[47:0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reset ready", 64'(reqReady), 64'h1);
    check(memReq == 1'b0, "R1 reset memReq", 64'(memReq), 64'h0);
    check(rspValid == 1'b0, "R1 reset rspValid", 64'(rspValid), 64'h0);

    // vector table walk
    for (int i = 0; i < NV; i++)
      runOne(VEC_VA[i], VEC_KIND[i], VEC_G[i], VEC_N[i], 1'b0);

    // R2: roots and further requests changed mid-walk are ignored
    runOne(64'h0000_0077_0123_4567, 0, 0, 0, 1'b1);
    // R9/R4: back-to-back translations, fault then success on the same table path
    runOne(64'h0000_0012_3456_7ABC, 1, 3, 2, 1'b0);
    runOne(64'h0000_0012_3456_7ABC, 0, 0, 0, 1'b0);
    // R8: guest fault at the root level
    runOne(64'h0000_0066_0000_0000, 2, 0, 0, 1'b0);

    finishRun();
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog global actual=timeout expected=done");
    finishRun();
  end

endmodule